// File: doc/BRIEF.md
# Control-Word Register Datapath

A single-cycle datapath built around eight general registers of parameterised width (default 8 bits). Each clock, a 16-bit control word picks two source registers and a destination register. It also picks the source of the second operand bus, the operation of the function unit, where the write-back value comes from, and whether a write happens at all.

The first operand bus always comes from a register. The second operand bus comes either from a register or from an external constant. The function unit combines the two buses through an adder with a selectable second input, bitwise logic, or a one-bit shifter working on the second bus. The write-back bus takes either that result or an external data word. It is stored into the destination register on the rising clock edge.

The first operand bus is driven out as an address and the second as outgoing data, so an outside memory can be wired to the block. Overflow, carry, sign and zero flags of the function unit are driven out combinationally. Sequencing the control words is the job of whatever drives the block.

Top module: `cw_datapath`

## Requirements
- R1: The control word is split as: destination register in bits 15:13, first source in 12:10, second source in 9:7, operand-B select in bit 6, function code in 5:2, write-back select in bit 1 and write enable in bit 0. A 3-bit register field value k selects register k. `addr_out` shows the register selected by bits 12:10.
- R2: With bit 6 at 0, `data_out` (the second operand bus) shows the register selected by bits 9:7. With bit 6 at 1, it shows `const_in`.
- R3: With bit 1 at 0, the write-back value is the function unit result. With bit 1 at 1, it is `data_in`.
- R4: With bit 0 at 1, the write-back value is stored into the destination register on the rising edge, and no other register changes. With bit 0 at 0, no register changes.
- R5: Register reads are combinational. A register that is both a source and the destination supplies its old value during the cycle and holds the new value after the edge.
- R6: A synchronous active-high `rst` clears all eight registers to zero at the clock edge.
- R7: Function codes 0000 to 0111 compute A + Y + c. Here c is code bit 0, and code bits 2:1 pick Y: 00 gives zero, 01 gives B, 10 gives ~B, 11 gives all ones. This yields A, A+1, A+B, A+B+1, A+~B, A-B, A-1 and A.
- R8: Function code 1000 gives A AND B, 1001 gives A OR B, 1010 gives A XOR B, and 1011 gives NOT A.
- R9: Function code 1100 passes B. Code 1101 shifts B right by one with a zero entering at the top. Code 1110 shifts B left by one with a zero entering at the bottom. Code 1111 gives zero.
- R10: `flag_n` is the result's top bit and `flag_z` is 1 when the result is zero. For codes 0xxx, `flag_c` is the adder carry out and `flag_v` is two's-complement overflow of A + Y + c. For codes 1xxx, both are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear of all registers |
| ctrl | input | 16 | Control word for the current cycle |
| const_in | input | W | External constant for the second operand bus |
| data_in | input | W | External data for the write-back bus |
| addr_out | output | W | First operand bus |
| data_out | output | W | Second operand bus |
| flag_v | output | 1 | Signed overflow of the function unit |
| flag_c | output | 1 | Carry out of the function unit |
| flag_n | output | 1 | Sign of the function unit result |
| flag_z | output | 1 | Zero result of the function unit |

## Verification
On every cycle, the in-module assertions check several things. Reset leaves all registers clear. A disabled write leaves every register untouched. An enabled write stores external data, a passed second bus, or the sum of the two buses into the selected destination.

Some behaviour only the bench scenarios can show. These are the full set of sixteen function codes with their flags swept against every constant value, and the old-value read when a register is both source and destination. They also include the requirement that a write disturbs no other register, which is read back register by register.

// File: rtl/cw_datapath.sv
module cw_datapath #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [15:0]  ctrl,
  input  logic [W-1:0] const_in,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] addr_out,
  output logic [W-1:0] data_out,
  output logic         flag_v,
  output logic         flag_c,
  output logic         flag_n,
  output logic         flag_z
);
  localparam int AW   = 3;
  localparam int NREG = 1 << AW;

  logic [NREG-1:0][W-1:0] rf;

  logic [AW-1:0] dst, src_a, src_b;
  logic          sel_k, sel_ext, wr;
  logic [3:0]    fn;

  assign dst     = ctrl[15:13];
  assign src_a   = ctrl[12:10];
  assign src_b   = ctrl[9:7];
  assign sel_k   = ctrl[6];
  assign fn      = ctrl[5:2];
  assign sel_ext = ctrl[1];
  assign wr      = ctrl[0];

  logic [W-1:0] bus_a, bus_b, bus_d, res, y;
  logic [W:0]   sum;
  logic [W-1:0] low;
  logic         c_into_msb;

  assign bus_a = rf[src_a];
  assign bus_b = sel_k ? const_in : rf[src_b];

  always_comb begin
    unique case (fn[2:1])
      2'b00:   y = '0;
      2'b01:   y = bus_b;
      2'b10:   y = ~bus_b;
      default: y = '1;
    endcase
    sum = {1'b0, bus_a} + {1'b0, y} + {{W{1'b0}}, fn[0]};
    low = {1'b0, bus_a[W-2:0]} + {1'b0, y[W-2:0]} + {{(W-1){1'b0}}, fn[0]};
    c_into_msb = low[W-1];
  end

  always_comb begin
    if (!fn[3]) res = sum[W-1:0];
    else begin
      unique case (fn[2:0])
        3'b000:  res = bus_a & bus_b;
        3'b001:  res = bus_a | bus_b;
        3'b010:  res = bus_a ^ bus_b;
        3'b011:  res = ~bus_a;
        3'b100:  res = bus_b;
        3'b101:  res = {1'b0, bus_b[W-1:1]};
        3'b110:  res = {bus_b[W-2:0], 1'b0};
        default: res = '0;
      endcase
    end
  end

  assign flag_c = !fn[3] && sum[W];
  assign flag_v = !fn[3] && (sum[W] ^ c_into_msb);
  assign flag_n = res[W-1];
  assign flag_z = (res == '0);

  assign bus_d    = sel_ext ? data_in : res;
  assign addr_out = bus_a;
  assign data_out = bus_b;

  always_ff @(posedge clk) begin
    if (rst)     rf <= '0;
    else if (wr) rf[dst] <= bus_d;
  end

  // R6
  reset_clear_chk: assert property (@(posedge clk) $past(rst) && !rst |-> rf == '0);

  // R4
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(rf));

  // R3
  ext_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr && sel_ext |=> rf[$past(dst)] == $past(data_in));

  // R2
  pass_b_chk: assert property (@(posedge clk) disable iff (rst)
    wr && !sel_ext && fn == 4'b1100 |=> rf[$past(dst)] == $past(data_out));

  // R7
  add_chk: assert property (@(posedge clk) disable iff (rst)
    wr && !sel_ext && fn == 4'b0010 |=> rf[$past(dst)] == $past(addr_out + data_out));
endmodule

// File: tb/test_cw_datapath.sv
module test_cw_datapath;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  ctrl = '0;
  logic [W-1:0] const_in = '0, data_in = '0;
  logic [W-1:0] addr_out, data_out;
  logic         flag_v, flag_c, flag_n, flag_z;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] model [8];

  cw_datapath #(.W(W)) i_cw_datapath (
    .clk(clk), .rst(rst), .ctrl(ctrl), .const_in(const_in), .data_in(data_in),
    .addr_out(addr_out), .data_out(data_out),
    .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z));

  always #10 clk = ~clk;

  function automatic logic [W+1:0] fu(input logic [3:0] fs, input logic [W-1:0] a, b);
    logic [W-1:0] y, f;
    logic [W:0]   s;
    logic         c, v;
    c = 1'b0; v = 1'b0;
    if (!fs[3]) begin
      y = (fs[2:1] == 2'd0) ? '0 : (fs[2:1] == 2'd1) ? b : (fs[2:1] == 2'd2) ? ~b : '1;
      s = a + y + fs[0];
      f = s[W-1:0];
      c = s[W];
      v = (a[W-1] == y[W-1]) && (f[W-1] != a[W-1]);
    end else begin
      case (fs[2:0])
        3'd0: f = a & b;
        3'd1: f = a | b;
        3'd2: f = a ^ b;
        3'd3: f = ~a;
        3'd4: f = b;
        3'd5: f = b / 2;
        3'd6: f = b * 2;
        default: f = '0;
      endcase
    end
    return {v, c, f};
  endfunction

  function automatic logic [15:0] cw(input int d, a, b, input logic mb,
                                     input logic [3:0] fs, input logic md, rw);
    return {d[2:0], a[2:0], b[2:0], mb, fs, md, rw};
  endfunction

  task automatic check(input string req, input logic [W+3:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] c, input logic [W-1:0] k, d);
    @(negedge clk);
    ctrl = c; const_in = k; data_in = d;
    #2;
  endtask

  task automatic tick;
    logic [W+1:0] r;
    logic [W-1:0] bv;
    bv = ctrl[6] ? const_in : model[ctrl[9:7]];
    r = fu(ctrl[5:2], model[ctrl[12:10]], bv);
    @(posedge clk);
    if (ctrl[0]) model[ctrl[15:13]] = ctrl[1] ? data_in : r[W-1:0];
  endtask

  task automatic read_all(input string req);
    for (int r = 0; r < 8; r++) begin
      drive(cw(0, r, 7 - r, 1'b0, 4'b0000, 1'b0, 1'b0), '0, '0);
      check(req, {4'b0, addr_out}, {4'b0, model[r]});
      check(req, {4'b0, data_out}, {4'b0, model[7 - r]});
      tick();
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W+1:0] e;
    for (int r = 0; r < 8; r++) model[r] = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    read_all("R6");
    // R3 R4: load every register from data_in
    for (int r = 0; r < 8; r++) begin
      drive(cw(r, 0, 0, 1'b0, 4'b1111, 1'b1, 1'b1), '0, W'(8'h3C + r * 37));
      tick();
    end
    read_all("R1 R3 R4");
    // R6: reset clears loaded registers
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    @(negedge clk); rst = 1'b0;
    for (int r = 0; r < 8; r++) model[r] = '0;
    read_all("R6");
    for (int r = 0; r < 8; r++) begin
      drive(cw(r, 0, 0, 1'b0, 4'b0000, 1'b1, 1'b1), '0, W'(8'h91 + r * 53));
      tick();
    end
    // R4: disabled write with external data changes nothing
    for (int r = 0; r < 8; r++) begin
      drive(cw(r, r, r, 1'b0, 4'b0000, 1'b1, 1'b0), '0, 8'h5A);
      tick();
    end
    read_all("R4");
    // R2: constant on bus B
    for (int k = 0; k < 256; k += 17) begin
      drive(cw(0, 2, 3, 1'b1, 4'b0000, 1'b0, 1'b0), W'(k), '0);
      check("R2", {4'b0, data_out}, {4'b0, W'(k)});
      tick();
    end
    // R7 R8 R9 R10: flag sweep over every code, register and constant
    for (int fs = 0; fs < 16; fs++)
      for (int a = 0; a < 8; a++)
        for (int k = 0; k < 256; k++) begin
          drive(cw(0, a, 0, 1'b1, 4'(fs), 1'b0, 1'b0), W'(k), '0);
          e = fu(4'(fs), model[a], W'(k));
          check(fs < 8 ? "R7 R10" : "R8 R9 R10",
                {flag_v, flag_c, flag_n, flag_z, 8'h00},
                {e[W+1], e[W], e[W-1], e[W-1:0] == '0, 8'h00});
          tick();
        end
    // R7 R8 R9 R4: write results to R7, read back all registers
    for (int fs = 0; fs < 16; fs++)
      for (int k = 0; k < 256; k += 37) begin
        drive(cw(7, fs % 7, 0, 1'b1, 4'(fs), 1'b0, 1'b1), W'(k), '0);
        tick();
        drive(cw(0, 7, 7, 1'b0, 4'b0000, 1'b0, 1'b0), '0, '0);
        check(fs < 8 ? "R7" : (fs < 12 ? "R8" : "R9"), {4'b0, addr_out}, {4'b0, model[7]});
        tick();
      end
    read_all("R4");
    // R5: R3 <- R3 + R1 shows old value before the edge
    drive(cw(3, 3, 1, 1'b0, 4'b0010, 1'b0, 1'b1), '0, '0);
    e = fu(4'b0010, model[3], model[1]);
    check("R5", {4'b0, addr_out}, {4'b0, model[3]});
    tick();
    drive(cw(0, 3, 3, 1'b0, 4'b0000, 1'b0, 1'b0), '0, '0);
    check("R5", {4'b0, addr_out}, {4'b0, e[W-1:0]});
    tick();
    // R3: external data wins over function result
    drive(cw(5, 2, 4, 1'b0, 4'b0010, 1'b1, 1'b1), '0, 8'hC3);
    tick();
    drive(cw(0, 5, 0, 1'b0, 4'b0000, 1'b0, 1'b0), '0, '0);
    check("R3", {4'b0, addr_out}, {4'b0, 8'hC3});
    tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule